// File: doc/BRIEF.md
# Transfer Descriptor Execution Unit

This unit sits between a host controller's schedule walker and its bus engine. When the walker has fetched a transfer descriptor, it presents the descriptor's control/status word and token word, together with the outcome of the bus transaction for that descriptor. The token fields (packet identifier, device address, endpoint and encoded maximum length) are decoded combinationally, so the walker can start the bus transaction in the same cycle. One clock later the unit returns three things: the rewritten control/status word, two interrupt-cause bits, and a two-bit result code. The code tells the walker to advance the queue element link, leave the descriptor in place, wait for an outstanding transaction, or abandon the frame.

The bus engine may report that a transaction is still in flight. The unit then records a single outstanding request. Until that request is resolved, every fresh descriptor is passed over untouched. The walker later re-presents the owning descriptor, with the resume flag set and the final outcome attached, to complete it. If the walker finds that the owning queue has gone from the schedule, it drops the request with a cancel strobe.

Control word bit positions follow the layout that the walker and software decode: actual length in bits 10:0, timeout/CRC 18, NAK 19, babble 20, stalled 22, active 23, interrupt-on-complete 24, isochronous select 25, error counter 28:27, short-packet detect 29. The token places the PID in 7:0, the address in 14:8, the endpoint in 18:15 and the encoded maximum length in 31:21.

Top module: `tdx_exec_unit`

## Requirements
- R1: The decode outputs give the token's PID (bits 7:0), device address (14:8), endpoint (18:15) and maximum length equal to (token[31:21] + 1) modulo 2048, so an encoded 0x7FF means zero bytes.
- R2: After reset out_valid, pending and out_cancel are 0; each in_valid produces exactly one out_valid pulse one clock later.
- R3: For a descriptor that is not passed over, control bit 24 (interrupt on complete) sets cause bit 0, even when the descriptor is inactive or the transaction is outstanding.
- R4: A descriptor with control bit 23 (active) clear returns code 1 (keep) with the control word unchanged.
- R5: An active descriptor whose PID is not 0x2D (SETUP), 0x69 (IN) or 0xE1 (OUT) returns code 3 (abort) with out_hcperr high and the control word unchanged.
- R6: On response kind 0 (success), bits 10:0 become (length − 1) modulo 2048 and bits 23 and 19 are cleared, with code 0 (advance). The length is the maximum length for SETUP/OUT and the returned length for IN.
- R7: An IN success whose returned length exceeds the maximum length is babble: bits 20 and 22 are set, bit 23 is cleared, bits 10:0 are kept, and the code is 1.
- R8: An IN success with bit 29 set and a returned length below the maximum length sets cause bit 1 and returns code 1 instead of 0.
- R9: With bit 25 (isochronous) set, bit 23 is cleared on every outcome other than wait and abort, including NAK.
- R10: Response kind 1 (NAK) sets bit 19 and returns code 1.
- R11: Response kind 3 (error) sets bit 18 and decrements the counter in bits 28:27 unless it is already 0. A step from 1 to 0 sets bit 22 and clears bit 23. Response kind 2 (stall) sets bit 22 and clears bit 23. Both return code 1.
- R12: Response kind 4 (in flight) returns code 2 (wait) with the word unchanged and raises pending. While pending, descriptors without in_resume return code 1 with no change and no cause. A resumed descriptor is processed with its final response and drops pending.
- R13: in_cancel while pending clears pending and gives one out_cancel pulse a clock later. Without a pending request it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor and response presented this cycle |
| in_ctrl | input | 32 | Control/status word of the descriptor |
| in_token | input | 32 | Token word of the descriptor |
| in_resume | input | 1 | Descriptor re-presented to finish the outstanding request |
| in_rsp_kind | input | 3 | Transaction outcome: 0 ok, 1 NAK, 2 stall, 3 error, 4 in flight |
| in_rsp_len | input | RSP_LEN_W | Byte count returned by the device for IN |
| in_cancel | input | 1 | Drop the outstanding request |
| dec_pid | output | 8 | Decoded packet identifier |
| dec_addr | output | 7 | Decoded device address |
| dec_ep | output | 4 | Decoded endpoint number |
| dec_max_len | output | 11 | Decoded maximum length in bytes |
| out_valid | output | 1 | Result valid |
| out_ctrl | output | 32 | Rewritten control/status word |
| out_cause | output | 2 | Interrupt causes: bit 0 completion, bit 1 short packet |
| out_code | output | 2 | 0 advance, 1 keep, 2 wait, 3 abort |
| out_hcperr | output | 1 | Host process error strobe |
| pending | output | 1 | An in-flight request is outstanding |
| out_cancel | output | 1 | Outstanding request was dropped |

## Verification
The hardest states to reach are those around the single outstanding request. These are a fresh descriptor arriving while a request is parked, a resumed descriptor that carries the final length, and a cancel of a parked request. The stimulus first parks a request with response kind 4 and checks pending at the port. It then sends an unrelated descriptor carrying interrupt-on-complete, whose silence shows that it was passed over. It then resumes with a short IN length, and in a later round parks again and cancels. The length corners are also driven: an encoded length of 0x7FF, a return one byte over the maximum, and an error counter stepping through 3, 1 and 0.

// File: rtl/tdx_pkg.sv
`timescale 1ns/1ps
package tdx_pkg;
  localparam int LEN_W    = 11;
  localparam int B_TMO    = 18;
  localparam int B_NAK    = 19;
  localparam int B_BABBLE = 20;
  localparam int B_STALL  = 22;
  localparam int B_ACTIVE = 23;
  localparam int B_IOC    = 24;
  localparam int B_IOS    = 25;
  localparam int B_ERR_LO = 27;
  localparam int B_SPD    = 29;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  localparam logic [2:0] RSP_OK    = 3'd0;
  localparam logic [2:0] RSP_NAK   = 3'd1;
  localparam logic [2:0] RSP_STALL = 3'd2;
  localparam logic [2:0] RSP_ERR   = 3'd3;
  localparam logic [2:0] RSP_ASYNC = 3'd4;

  typedef enum logic [1:0] {
    TDX_ADVANCE = 2'd0,
    TDX_KEEP    = 2'd1,
    TDX_WAIT    = 2'd2,
    TDX_ABORT   = 2'd3
  } td_code_e;

  function automatic logic [LEN_W-1:0] max_len_of(input logic [31:0] tok);
    return tok[31:21] + 11'd1;
  endfunction

  function automatic logic [LEN_W-1:0] len_to_field(input logic [LEN_W-1:0] len);
    return len - 11'd1;
  endfunction

  function automatic logic pid_known(input logic [7:0] pid);
    return (pid == PID_SETUP) || (pid == PID_IN) || (pid == PID_OUT);
  endfunction
endpackage

// File: rtl/tdx_token_decode.sv
`timescale 1ns/1ps
module tdx_token_decode
  import tdx_pkg::*;
(
  input  logic [31:0]      token,
  output logic [7:0]       pid,
  output logic [6:0]       addr,
  output logic [3:0]       ep,
  output logic [LEN_W-1:0] max_len
);
  assign pid     = token[7:0];
  assign addr    = token[14:8];
  assign ep      = token[18:15];
  assign max_len = max_len_of(token);
endmodule

// File: rtl/tdx_ctrl_update.sv
`timescale 1ns/1ps
module tdx_ctrl_update
  import tdx_pkg::*;
#(
  parameter int RSP_LEN_W = 12
) (
  input  logic                 proc_en,
  input  logic [31:0]          ctrl,
  input  logic [7:0]           pid,
  input  logic [LEN_W-1:0]     max_len,
  input  logic [2:0]           rsp_kind,
  input  logic [RSP_LEN_W-1:0] rsp_len,
  output logic [31:0]          nxt_ctrl,
  output logic [1:0]           cause,
  output td_code_e             code,
  output logic                 hcperr
);
  logic                 is_in;
  logic [RSP_LEN_W-1:0] max_ext;
  logic                 babble;
  logic                 short_pkt;
  logic [LEN_W-1:0]     len_eff;
  logic [1:0]           errcnt;

  assign is_in     = (pid == PID_IN);
  assign max_ext   = RSP_LEN_W'(max_len);
  assign babble    = is_in && (rsp_len > max_ext);
  assign short_pkt = is_in && ctrl[B_SPD] && (rsp_len < max_ext);
  assign len_eff   = is_in ? rsp_len[LEN_W-1:0] : max_len;
  assign errcnt    = ctrl[B_ERR_LO +: 2];

  always_comb begin
    nxt_ctrl = ctrl;
    cause    = 2'b00;
    code     = TDX_KEEP;
    hcperr   = 1'b0;
    if (proc_en) begin
      cause[0] = ctrl[B_IOC];
      if (!ctrl[B_ACTIVE]) begin
        code = TDX_KEEP;
      end else if (!pid_known(pid)) begin
        code   = TDX_ABORT;
        hcperr = 1'b1;
      end else if (rsp_kind == RSP_ASYNC) begin
        code = TDX_WAIT;
      end else begin
        if (ctrl[B_IOS]) nxt_ctrl[B_ACTIVE] = 1'b0;
        case (rsp_kind)
          RSP_OK: begin
            if (babble) begin
              nxt_ctrl[B_BABBLE] = 1'b1;
              nxt_ctrl[B_STALL]  = 1'b1;
              nxt_ctrl[B_ACTIVE] = 1'b0;
            end else begin
              nxt_ctrl[LEN_W-1:0] = len_to_field(len_eff);
              nxt_ctrl[B_ACTIVE]  = 1'b0;
              nxt_ctrl[B_NAK]     = 1'b0;
              if (short_pkt) begin
                cause[1] = 1'b1;
                code     = TDX_KEEP;
              end else begin
                code = TDX_ADVANCE;
              end
            end
          end
          RSP_NAK: nxt_ctrl[B_NAK] = 1'b1;
          RSP_STALL: begin
            nxt_ctrl[B_STALL]  = 1'b1;
            nxt_ctrl[B_ACTIVE] = 1'b0;
          end
          default: begin
            nxt_ctrl[B_TMO] = 1'b1;
            if (errcnt != 2'd0) begin
              nxt_ctrl[B_ERR_LO +: 2] = errcnt - 2'd1;
              if (errcnt == 2'd1) begin
                nxt_ctrl[B_STALL]  = 1'b1;
                nxt_ctrl[B_ACTIVE] = 1'b0;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tdx_async_tracker.sv
`timescale 1ns/1ps
module tdx_async_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start_async,
  input  logic finish_async,
  input  logic cancel,
  output logic pending,
  output logic cancel_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      cancel_ack <= 1'b0;
    end else begin
      cancel_ack <= cancel && pending && !start_async;
      if (start_async)
        pending <= 1'b1;
      else if (finish_async || cancel)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/tdx_exec_unit.sv
`timescale 1ns/1ps
module tdx_exec_unit
  import tdx_pkg::*;
#(
  parameter int RSP_LEN_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [31:0]          in_ctrl,
  input  logic [31:0]          in_token,
  input  logic                 in_resume,
  input  logic [2:0]           in_rsp_kind,
  input  logic [RSP_LEN_W-1:0] in_rsp_len,
  input  logic                 in_cancel,
  output logic [7:0]           dec_pid,
  output logic [6:0]           dec_addr,
  output logic [3:0]           dec_ep,
  output logic [10:0]          dec_max_len,
  output logic                 out_valid,
  output logic [31:0]          out_ctrl,
  output logic [1:0]           out_cause,
  output logic [1:0]           out_code,
  output logic                 out_hcperr,
  output logic                 pending,
  output logic                 out_cancel
);
  logic        proc_en;
  logic [31:0] upd_ctrl;
  logic [1:0]  upd_cause;
  td_code_e    upd_code;
  logic        upd_hcperr;
  logic        start_async;
  logic        finish_async;

  tdx_token_decode u_dec (
    .token   (in_token),
    .pid     (dec_pid),
    .addr    (dec_addr),
    .ep      (dec_ep),
    .max_len (dec_max_len)
  );

  // A parked request admits only the resumed descriptor; otherwise only fresh ones.
  assign proc_en = (pending == in_resume);

  tdx_ctrl_update #(.RSP_LEN_W(RSP_LEN_W)) u_upd (
    .proc_en  (proc_en),
    .ctrl     (in_ctrl),
    .pid      (dec_pid),
    .max_len  (dec_max_len),
    .rsp_kind (in_rsp_kind),
    .rsp_len  (in_rsp_len),
    .nxt_ctrl (upd_ctrl),
    .cause    (upd_cause),
    .code     (upd_code),
    .hcperr   (upd_hcperr)
  );

  assign start_async  = in_valid && proc_en && (upd_code == TDX_WAIT);
  assign finish_async = in_valid && proc_en && in_resume && (upd_code != TDX_WAIT);

  tdx_async_tracker u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_async  (start_async),
    .finish_async (finish_async),
    .cancel       (in_cancel),
    .pending      (pending),
    .cancel_ack   (out_cancel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_ctrl   <= '0;
      out_cause  <= '0;
      out_code   <= '0;
      out_hcperr <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_hcperr <= in_valid && upd_hcperr;
      if (in_valid) begin
        out_ctrl  <= upd_ctrl;
        out_cause <= upd_cause;
        out_code  <= upd_code;
      end
    end
  end
endmodule

// File: rtl/tdx_exec_chk.sv
`timescale 1ns/1ps
module tdx_exec_chk
  import tdx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_ctrl,
  input logic        in_resume,
  input logic        pending,
  input logic        out_valid,
  input logic [31:0] out_ctrl,
  input logic [1:0]  out_cause,
  input logic [1:0]  out_code,
  input logic        out_hcperr,
  input logic        out_cancel
);
  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  ioc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[B_IOC] && (pending == in_resume)) |=> out_cause[0]);
  // R4
  inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ctrl[B_ACTIVE]) |=>
      (out_ctrl == $past(in_ctrl)) && (out_code == TDX_KEEP));
  // R5
  abort_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hcperr |-> (out_valid && out_code == TDX_ABORT));
  // R5
  abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == TDX_ABORT) |-> out_hcperr);
  // R6
  advance_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == TDX_ADVANCE) |-> (!out_ctrl[B_ACTIVE] && !out_ctrl[B_NAK]));
  // R12
  wait_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == TDX_WAIT) |-> pending);
  // R12
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pending && !in_resume) |=> (out_code == TDX_KEEP && out_cause == 2'b00));
  // R13
  cancel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cancel |-> !pending);
endmodule

bind tdx_exec_unit tdx_exec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ctrl    (in_ctrl),
  .in_resume  (in_resume),
  .pending    (pending),
  .out_valid  (out_valid),
  .out_ctrl   (out_ctrl),
  .out_cause  (out_cause),
  .out_code   (out_code),
  .out_hcperr (out_hcperr),
  .out_cancel (out_cancel)
);

// File: tb/tdx_exec_unit_tb.sv
`timescale 1ns/1ps
module tdx_exec_unit_tb;
  localparam int RLW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     in_ctrl = '0;
  logic [31:0]     in_token = '0;
  logic            in_resume = 1'b0;
  logic [2:0]      in_rsp_kind = '0;
  logic [RLW-1:0]  in_rsp_len = '0;
  logic            in_cancel = 1'b0;
  logic [7:0]      dec_pid;
  logic [6:0]      dec_addr;
  logic [3:0]      dec_ep;
  logic [10:0]     dec_max_len;
  logic            out_valid;
  logic [31:0]     out_ctrl;
  logic [1:0]      out_cause;
  logic [1:0]      out_code;
  logic            out_hcperr;
  logic            pending;
  logic            out_cancel;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] ctrl;
    logic [1:0]  cause;
    logic [1:0]  code;
    logic        hcperr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  tdx_exec_unit #(.RSP_LEN_W(RLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_token(in_token), .in_resume(in_resume), .in_rsp_kind(in_rsp_kind),
    .in_rsp_len(in_rsp_len), .in_cancel(in_cancel), .dec_pid(dec_pid),
    .dec_addr(dec_addr), .dec_ep(dec_ep), .dec_max_len(dec_max_len),
    .out_valid(out_valid), .out_ctrl(out_ctrl), .out_cause(out_cause),
    .out_code(out_code), .out_hcperr(out_hcperr), .pending(pending),
    .out_cancel(out_cancel)
  );

  function automatic logic [31:0] mk_tok(input logic [7:0] pid, input logic [6:0] addr,
                                         input logic [3:0] ep, input logic [10:0] raw);
    return {raw, 2'b00, ep, addr, pid};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] c, input logic [31:0] t, input logic res,
                      input logic [2:0] k, input logic [RLW-1:0] l,
                      input logic [31:0] ec, input logic [1:0] ecause,
                      input logic [1:0] ecode, input logic eh, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = c; in_token = t; in_resume = res;
    in_rsp_kind = k; in_rsp_len = l;
    e.ctrl = ec; e.cause = ecause; e.code = ecode; e.hcperr = eh; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; in_resume = 1'b0;
  endtask

  // monitor: pops one expected item per result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected result", 32'(out_code), 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_ctrl == e.ctrl, {e.tag, " ctrl"}, out_ctrl, e.ctrl);
        check(out_cause == e.cause, {e.tag, " cause"}, 32'(out_cause), 32'(e.cause));
        check(out_code == e.code, {e.tag, " code"}, 32'(out_code), 32'(e.code));
        check(out_hcperr == e.hcperr, {e.tag, " hcperr"}, 32'(out_hcperr), 32'(e.hcperr));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check(out_valid == 1'b0 && pending == 1'b0 && out_cancel == 1'b0,
          "R2 reset", {29'd0, out_valid, pending, out_cancel}, 32'd0);
    rst_n = 1'b1;

    // R1 decode
    @(negedge clk);
    in_token = mk_tok(8'h69, 7'h55, 4'hA, 11'd7);
    #1;
    check(dec_pid == 8'h69 && dec_addr == 7'h55 && dec_ep == 4'hA && dec_max_len == 11'd8,
          "R1 decode", {dec_pid, 1'b0, dec_addr, dec_ep, 1'b0, dec_max_len}, 32'h6955_A008);
    in_token = mk_tok(8'hE1, 7'h01, 4'h3, 11'h7FF);
    #1;
    check(dec_max_len == 11'd0, "R1 null length", 32'(dec_max_len), 32'd0);

    // R6 OUT success, max 8
    send(32'h1880_0000, mk_tok(8'hE1, 7'h01, 4'h1, 11'd7), 0, 3'd0, 12'd0,
         32'h1800_0007, 2'b00, 2'd0, 0, "R6 out ok");
    // R8 R3 short IN with spd, ioc, stale nak
    send(32'h2188_0000, mk_tok(8'h69, 7'h02, 4'h1, 11'd63), 0, 3'd0, 12'd10,
         32'h2100_0009, 2'b11, 2'd1, 0, "R8 short in");
    // R8 full IN with spd, no short
    send(32'h2080_0000, mk_tok(8'h69, 7'h02, 4'h1, 11'd63), 0, 3'd0, 12'd64,
         32'h2000_003F, 2'b00, 2'd0, 0, "R8 full in");
    // R6 R1 zero length packet
    send(32'h0080_0000, mk_tok(8'h69, 7'h02, 4'h2, 11'h7FF), 0, 3'd0, 12'd0,
         32'h0000_07FF, 2'b00, 2'd0, 0, "R6 zero length");
    // R7 babble, one byte over
    send(32'h0080_0000, mk_tok(8'h69, 7'h02, 4'h2, 11'd7), 0, 3'd0, 12'd9,
         32'h0050_0000, 2'b00, 2'd1, 0, "R7 babble");
    // R4 R3 inactive with ioc
    send(32'h0100_0123, mk_tok(8'hE1, 7'h03, 4'h0, 11'd7), 0, 3'd0, 12'd0,
         32'h0100_0123, 2'b01, 2'd1, 0, "R4 inactive");
    // R5 bad pid
    send(32'h0080_0000, mk_tok(8'hA5, 7'h03, 4'h0, 11'd7), 0, 3'd0, 12'd0,
         32'h0080_0000, 2'b00, 2'd3, 1, "R5 bad pid");
    // R10 NAK on SETUP
    send(32'h1880_0000, mk_tok(8'h2D, 7'h04, 4'h0, 11'd7), 0, 3'd1, 12'd0,
         32'h1888_0000, 2'b00, 2'd1, 0, "R10 nak");
    // R9 isochronous NAK clears active
    send(32'h0280_0000, mk_tok(8'hE1, 7'h04, 4'h5, 11'd31), 0, 3'd1, 12'd0,
         32'h0208_0000, 2'b00, 2'd1, 0, "R9 iso nak");
    // R11 error counter 3 -> 2
    send(32'h1880_0000, mk_tok(8'hE1, 7'h05, 4'h0, 11'd7), 0, 3'd3, 12'd0,
         32'h1084_0000, 2'b00, 2'd1, 0, "R11 err 3");
    // R11 error counter 1 -> 0, retire
    send(32'h0880_0000, mk_tok(8'hE1, 7'h05, 4'h0, 11'd7), 0, 3'd3, 12'd0,
         32'h0044_0000, 2'b00, 2'd1, 0, "R11 err 1");
    // R11 error counter 0 stays
    send(32'h0080_0000, mk_tok(8'hE1, 7'h05, 4'h0, 11'd7), 0, 3'd3, 12'd0,
         32'h0084_0000, 2'b00, 2'd1, 0, "R11 err 0");
    // R11 stall
    send(32'h1880_0000, mk_tok(8'h69, 7'h05, 4'h0, 11'd7), 0, 3'd2, 12'd0,
         32'h1840_0000, 2'b00, 2'd1, 0, "R11 stall");

    // R12 park a request
    send(32'h0180_0000, mk_tok(8'h69, 7'h06, 4'h1, 11'd63), 0, 3'd4, 12'd0,
         32'h0180_0000, 2'b01, 2'd2, 0, "R12 wait");
    check(pending == 1'b1, "R12 pending set", 32'(pending), 32'd1);
    // R12 fresh descriptor passed over, no cause
    send(32'h0180_0000, mk_tok(8'hE1, 7'h07, 4'h1, 11'd7), 0, 3'd0, 12'd0,
         32'h0180_0000, 2'b00, 2'd1, 0, "R12 skipped");
    check(pending == 1'b1, "R12 pending held", 32'(pending), 32'd1);
    // R12 resume with final length
    send(32'h0080_0000, mk_tok(8'h69, 7'h06, 4'h1, 11'd63), 1, 3'd0, 12'd5,
         32'h0000_0004, 2'b00, 2'd0, 0, "R12 resume");
    check(pending == 1'b0, "R12 pending cleared", 32'(pending), 32'd0);

    // R13 park again then cancel
    send(32'h0080_0000, mk_tok(8'h2D, 7'h08, 4'h0, 11'd7), 0, 3'd4, 12'd0,
         32'h0080_0000, 2'b00, 2'd2, 0, "R13 wait");
    @(negedge clk);
    in_cancel = 1'b1;
    @(negedge clk);
    in_cancel = 1'b0;
    check(out_cancel == 1'b1, "R13 cancel pulse", 32'(out_cancel), 32'd1);
    check(pending == 1'b0, "R13 pending dropped", 32'(pending), 32'd0);
    @(negedge clk);
    check(out_cancel == 1'b0, "R13 single pulse", 32'(out_cancel), 32'd0);
    // R13 cancel with nothing parked
    in_cancel = 1'b1;
    @(negedge clk);
    in_cancel = 1'b0;
    check(out_cancel == 1'b0, "R13 idle cancel", 32'(out_cancel), 32'd0);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 results missing", 32'(sb.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule